// File: doc/BRIEF.md
# Data-Processing ALU with Registered Condition Flags

This block is the integer execution core of a data-processing pipeline stage. In a single combinational pass it turns a 4-bit operation code and two 32-bit operands into a result word and a write-enable for that result. The second operand arrives already shifted or rotated by an upstream shifter, together with that shifter's carry-out.

Four condition flags (negative, zero, carry, overflow) are held in a register inside the block. They feed the carry-in of the chained arithmetic operations. They are replaced on a clock edge only when the set-flags input is high.

Arithmetic operations take their carry and overflow from a single shared adder. The adder's inputs are steered according to the operation class. Logical operations take carry from the shifter and leave overflow untouched. The four compare and test codes update the flags without asking for a register write.

Top module: `dp_alu`

## Requirements
- R1: `result_o` is computed combinationally from `op_i`, where a = `opa_i` and b = `opb_i`. The encoding is: 0 a AND b, 1 a XOR b, 2 a−b, 3 b−a, 4 a+b, 5 a+b+C, 6 a−b−(NOT C), 7 b−a−(NOT C), 8 a AND b, 9 a XOR b, 10 a−b, 11 a+b, 12 a OR b, 13 b, 14 a AND NOT b, 15 NOT b.
- R2: Codes 5, 6 and 7 use the registered carry flag (`flags_o[1]`) as their carry-in. The other arithmetic codes use a fixed carry-in: 0 for 4 and 11, and 1 for 2, 3 and 10.
- R3: `wr_en_o` is low for codes 8 to 11 and high for every other code.
- R4: For codes 4, 5 and 11, C and V are the carry-out and the signed overflow of the addition a + b + cin.
- R5: For codes 2, 6 and 10, C and V are those of the addition a + (NOT b) + cin, so C = 1 means that no borrow occurred.
- R6: For codes 3 and 7, C and V are those of the addition b + (NOT a) + cin.
- R7: For logical codes (0, 1, 8, 9, 12, 13, 14, 15), V keeps its previous value. C takes `shift_carry_i` when `shift_carry_live_i` is high, and otherwise keeps its previous value.
- R8: On every flag update, N takes bit 31 of the result, and Z is 1 exactly when the result is all zero.
- R9: Flags are written at a rising clock edge only when `set_flags_i` is high; otherwise all four flags hold.
- R10: While `rst_n` is low, the flags are cleared to 0. `flags_o` is packed as {N, Z, C, V}, with N in bit 3 and V in bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_i | input | 4 | Operation code |
| opa_i | input | 32 | First operand a |
| opb_i | input | 32 | Shifted second operand b |
| shift_carry_i | input | 1 | Carry-out of the shifter or rotator |
| shift_carry_live_i | input | 1 | High when the shift amount was nonzero, so its carry is meaningful |
| set_flags_i | input | 1 | Flag update enable |
| result_o | output | 32 | Operation result |
| wr_en_o | output | 1 | Result write-enable |
| flags_o | output | 4 | Registered flags {N, Z, C, V} |

## Verification
Two things can happen in the same cycle: the carry-in variants read the registered C flag, and the same edge replaces that flag. The bench drives back-to-back flag-setting operations so that the carry produced by one operation is consumed by the next ADC, SBC or RSC, with no gap between them. Expected values come from a bench-side flag model that advances only on cycles where set-flags is high. The bench judges the combinational result before the edge and the flags after it.

// File: rtl/dp_alu_pkg.sv
package dp_alu_pkg;

    typedef enum logic [3:0] {
        OP_AND = 4'h0, OP_EOR = 4'h1, OP_SUB = 4'h2, OP_RSB = 4'h3,
        OP_ADD = 4'h4, OP_ADC = 4'h5, OP_SBC = 4'h6, OP_RSC = 4'h7,
        OP_TST = 4'h8, OP_TEQ = 4'h9, OP_CMP = 4'hA, OP_CMN = 4'hB,
        OP_ORR = 4'hC, OP_MOV = 4'hD, OP_BIC = 4'hE, OP_MVN = 4'hF
    } alu_op_e;

    // How carry and overflow are formed
    typedef enum logic [1:0] {
        CLS_LOGIC = 2'd0,
        CLS_ADD   = 2'd1,
        CLS_SUB   = 2'd2,
        CLS_RSUB  = 2'd3
    } op_cls_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } nzcv_t;

endpackage

// File: rtl/dp_alu_decode.sv
module dp_alu_decode
    import dp_alu_pkg::*;
(
    input  logic [3:0] op_i,
    output op_cls_e    cls_o,
    output logic       chain_o,
    output logic       writes_o
);
    alu_op_e op;
    assign op = alu_op_e'(op_i);

    always_comb begin
        cls_o    = CLS_LOGIC;
        chain_o  = 1'b0;
        writes_o = 1'b1;
        unique case (op)
            OP_ADD, OP_CMN: cls_o = CLS_ADD;
            OP_ADC: begin
                cls_o   = CLS_ADD;
                chain_o = 1'b1;
            end
            OP_SUB, OP_CMP: cls_o = CLS_SUB;
            OP_SBC: begin
                cls_o   = CLS_SUB;
                chain_o = 1'b1;
            end
            OP_RSB: cls_o = CLS_RSUB;
            OP_RSC: begin
                cls_o   = CLS_RSUB;
                chain_o = 1'b1;
            end
            default: cls_o = CLS_LOGIC;
        endcase
        if (op inside {OP_TST, OP_TEQ, OP_CMP, OP_CMN}) begin
            writes_o = 1'b0;
        end
    end
endmodule

// File: rtl/dp_alu_adder.sv
module dp_alu_adder #(
    parameter int W = 32
) (
    input  logic [W-1:0] x_i,
    input  logic [W-1:0] y_i,
    input  logic         cin_i,
    output logic [W-1:0] sum_o,
    output logic         cout_o,
    output logic         ovf_o
);
    localparam int MSB = W - 1;

    logic [W:0] wide;

    always_comb begin
        wide   = {1'b0, x_i} + {1'b0, y_i} + {{W{1'b0}}, cin_i};
        sum_o  = wide[MSB:0];
        cout_o = wide[W];
        ovf_o  = (x_i[MSB] == y_i[MSB]) && (wide[MSB] != x_i[MSB]);
    end
endmodule

// File: rtl/dp_alu_logic.sv
module dp_alu_logic
    import dp_alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [3:0]   op_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] res_o
);
    alu_op_e op;
    assign op = alu_op_e'(op_i);

    always_comb begin
        unique case (op)
            OP_AND, OP_TST: res_o = a_i & b_i;
            OP_EOR, OP_TEQ: res_o = a_i ^ b_i;
            OP_ORR:         res_o = a_i | b_i;
            OP_MOV:         res_o = b_i;
            OP_BIC:         res_o = a_i & ~b_i;
            OP_MVN:         res_o = ~b_i;
            default:        res_o = '0;
        endcase
    end
endmodule

// File: rtl/dp_alu.sv
module dp_alu
    import dp_alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [3:0]   op_i,
    input  logic [W-1:0] opa_i,
    input  logic [W-1:0] opb_i,
    input  logic         shift_carry_i,
    input  logic         shift_carry_live_i,
    input  logic         set_flags_i,
    output logic [W-1:0] result_o,
    output logic         wr_en_o,
    output logic [3:0]   flags_o
);
    localparam int MSB = W - 1;

    typedef struct packed {
        nzcv_t flags;
    } state_t;

    state_t  st_d, st_q;
    op_cls_e cls;
    logic    chain, writes;
    logic [W-1:0] add_x, add_y, add_sum, log_res;
    logic    add_cin, add_cout, add_ovf;

    dp_alu_decode u_dec (
        .op_i     (op_i),
        .cls_o    (cls),
        .chain_o  (chain),
        .writes_o (writes)
    );

    dp_alu_logic #(.W(W)) u_log (
        .op_i  (op_i),
        .a_i   (opa_i),
        .b_i   (opb_i),
        .res_o (log_res)
    );

    // Steer the shared adder by class
    always_comb begin
        add_x   = opa_i;
        add_y   = opb_i;
        add_cin = 1'b0;
        unique case (cls)
            CLS_ADD: begin
                add_cin = chain ? st_q.flags.c : 1'b0;
            end
            CLS_SUB: begin
                add_y   = ~opb_i;
                add_cin = chain ? st_q.flags.c : 1'b1;
            end
            CLS_RSUB: begin
                add_x   = opb_i;
                add_y   = ~opa_i;
                add_cin = chain ? st_q.flags.c : 1'b1;
            end
            default: ;
        endcase
    end

    dp_alu_adder #(.W(W)) u_add (
        .x_i    (add_x),
        .y_i    (add_y),
        .cin_i  (add_cin),
        .sum_o  (add_sum),
        .cout_o (add_cout),
        .ovf_o  (add_ovf)
    );

    always_comb begin
        result_o = (cls == CLS_LOGIC) ? log_res : add_sum;
        wr_en_o  = writes;
        st_d     = st_q;
        if (set_flags_i) begin
            st_d.flags.n = result_o[MSB];
            st_d.flags.z = (result_o == '0);
            if (cls == CLS_LOGIC) begin
                if (shift_carry_live_i) begin
                    st_d.flags.c = shift_carry_i;
                end
            end else begin
                st_d.flags.c = add_cout;
                st_d.flags.v = add_ovf;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flags_o = st_q.flags;
endmodule

// File: rtl/dp_alu_chk.sv
module dp_alu_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic [3:0]   op_i,
    input logic         set_flags_i,
    input logic [W-1:0] result_o,
    input logic         wr_en_o,
    input logic [3:0]   flags_o
);
    logic is_logic;
    assign is_logic = op_i inside {4'h0, 4'h1, 4'h8, 4'h9, 4'hC, 4'hD, 4'hE, 4'hF};

    AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !set_flags_i |=> $stable(flags_o)); // R9
    AST_NO_WR_COMPARE: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i[3:2] == 2'b10) |-> !wr_en_o); // R3
    AST_WR_OTHERS: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i[3:2] != 2'b10) |-> wr_en_o); // R3
    AST_Z_FROM_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        set_flags_i |=> (flags_o[2] == ($past(result_o) == '0))); // R8
    AST_N_FROM_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        set_flags_i |=> (flags_o[3] == $past(result_o[W-1]))); // R8
    AST_LOGIC_V_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (set_flags_i && is_logic) |=> (flags_o[0] == $past(flags_o[0]))); // R7
endmodule

bind dp_alu dp_alu_chk #(.W(W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .op_i        (op_i),
    .set_flags_i (set_flags_i),
    .result_o    (result_o),
    .wr_en_o     (wr_en_o),
    .flags_o     (flags_o)
);

// File: tb/test_dp_alu.sv
`timescale 1ns/1ps
module test_dp_alu;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  op = 4'h0;
    logic [31:0] a = '0, b = '0;
    logic        shc = 1'b0, live = 1'b0, sf = 1'b0;
    logic [31:0] result;
    logic        wr_en;
    logic [3:0]  flags;

    int errors = 0;
    int checks = 0;
    logic [3:0] exp_flags = 4'h0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    dp_alu i_dp_alu (
        .clk(clk), .rst_n(rst_n), .op_i(op), .opa_i(a), .opb_i(b),
        .shift_carry_i(shc), .shift_carry_live_i(live), .set_flags_i(sf),
        .result_o(result), .wr_en_o(wr_en), .flags_o(flags)
    );

    // Returns {wr, N, Z, C, V, result}
    function automatic logic [36:0] model(input logic [3:0] o, input logic [31:0] x0,
                                          input logic [31:0] y0, input logic sc,
                                          input logic lv, input logic [3:0] f);
        logic [31:0] r, x, y;
        logic c, v, ci, arith;
        longint sx;
        logic [32:0] s;
        c = f[1]; v = f[0]; arith = 1'b1; x = x0; y = y0; ci = 1'b0; r = '0;
        case (o)
            4'h4, 4'hB: begin ci = 1'b0; end
            4'h5: begin ci = f[1]; end
            4'h2, 4'hA: begin y = ~y0; ci = 1'b1; end
            4'h6: begin y = ~y0; ci = f[1]; end
            4'h3: begin x = y0; y = ~x0; ci = 1'b1; end
            4'h7: begin x = y0; y = ~x0; ci = f[1]; end
            default: arith = 1'b0;
        endcase
        if (arith) begin
            s  = {1'b0, x} + {1'b0, y} + {32'd0, ci};
            r  = s[31:0];
            c  = s[32];
            sx = longint'($signed(x)) + longint'($signed(y)) + longint'(ci);
            v  = (sx > 64'sd2147483647) || (sx < -64'sd2147483648);
        end else begin
            case (o)
                4'h0, 4'h8: r = x0 & y0;
                4'h1, 4'h9: r = x0 ^ y0;
                4'hC: r = x0 | y0;
                4'hD: r = y0;
                4'hE: r = x0 & ~y0;
                default: r = ~y0;
            endcase
            if (lv) c = sc;
        end
        return {!(o inside {4'h8, 4'h9, 4'hA, 4'hB}), r[31], (r == 32'd0), c, v, r};
    endfunction

    function automatic string req_of(input logic [3:0] o);
        if (o inside {4'h5, 4'h6, 4'h7}) return "R2";
        if (o inside {4'h4, 4'hB}) return "R4";
        if (o inside {4'h2, 4'hA}) return "R5";
        if (o == 4'h3) return "R6";
        return "R7";
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step(input logic [3:0] o, input logic [31:0] x, input logic [31:0] y,
                        input logic sc, input logic lv, input logic s);
        logic [36:0] e;
        @(negedge clk);
        op = o; a = x; b = y; shc = sc; live = lv; sf = s;
        e = model(o, x, y, sc, lv, exp_flags);
        #5;
        chk("R1 result", 64'(result), 64'(e[31:0]));
        chk("R3 wr_en", 64'(wr_en), 64'(e[36]));
        @(posedge clk);
        #1;
        if (s) exp_flags = e[35:32];
        chk(s ? {req_of(o), "/R8 flags"} : "R9 flags hold", 64'(flags), 64'(exp_flags));
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(posedge clk);
        #1;
        chk("R10 reset flags", 64'(flags), 64'h0);
        @(negedge clk);
        rst_n = 1'b1;
        // Directed corners
        step(4'h4, 32'h7FFF_FFFF, 32'h1, 0, 0, 1);          // R4 signed overflow
        step(4'h4, 32'hFFFF_FFFF, 32'h1, 0, 0, 1);          // R4 carry, R8 zero
        step(4'h2, 32'd5, 32'd5, 0, 0, 1);                  // R5 no borrow
        step(4'h5, 32'd1, 32'd2, 0, 0, 1);                  // R2 ADC with C=1
        step(4'h2, 32'd3, 32'd5, 0, 0, 1);                  // R5 borrow
        step(4'h6, 32'd10, 32'd3, 0, 0, 1);                 // R2 SBC with C=0
        step(4'h3, 32'd1, 32'h8000_0000, 0, 0, 1);          // R6 overflow
        step(4'h7, 32'd4, 32'd4, 0, 0, 1);                  // R2 RSC chained
        step(4'hA, 32'd9, 32'd9, 0, 0, 1);                  // R3 compare, no write
        step(4'h4, 32'h7FFF_FFFF, 32'h1, 0, 0, 1);          // set V
        step(4'h0, 32'hF0F0_0000, 32'hFFFF_0000, 1, 1, 1);  // R7 C from shifter, V kept
        step(4'hC, 32'h0, 32'h0, 0, 0, 1);                  // R7 C kept when not live
        step(4'hD, 32'h0, 32'h1234, 0, 1, 0);               // R9 hold
        step(4'hF, 32'h0, 32'h0, 0, 1, 1);                  // R1 MVN
        step(4'h9, 32'hAAAA_AAAA, 32'hAAAA_AAAA, 1, 1, 1);  // R3 TEQ
        // Random mix
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] ra, rb;
            ra = $urandom;
            rb = $urandom;
            if (($urandom % 8) == 0) rb = ra;
            if (($urandom % 8) == 0) ra = 32'h8000_0000;
            step(4'($urandom), ra, rb, 1'($urandom), 1'($urandom), (($urandom % 4) != 0));
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule